// File: doc/BRIEF.md
# Mask-Selected Bit Scatter Counter

This block is a synchronous up-counter whose visible value moves only in the bit positions picked by a run-time select mask. Inside, an ordinary binary counter runs. A combinational deposit network then places the counter's low-order bits into the set positions of the mask, in order. Every other output bit reads zero. The counter wraps after the pattern in which every selected bit is one, so the period is two to the power of the number of selected bits.

Each clock edge, a small decision stage picks one of four named step actions, and the counter register applies it:

- `STEP_CLEAR` applies when reset is high and loads zero.
- `STEP_HOLD` applies when enable is low and keeps the value.
- `STEP_WRAP` applies when enable is high and the selected low bits are all ones. It loads zero.
- `STEP_INC` applies in every other enabled cycle and adds one.

The four actions have this priority: reset first, then hold, then wrap, then increment. The mask can change at any time. The output shows the new placement at once, with no clock edge needed.

Top module: `scatter_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the count to zero. Reset takes priority over `cnt_en`.
- R2: Every output bit whose `sel_mask` bit is 0 reads 0 at all times.
- R3: Set mask bits, taken from index 0 upward, carry count bits 0, 1, 2 and so on. The lowest set mask bit is the least significant count bit.
- R4: With `cnt_en` low and `rst` low, the count does not change at a rising edge.
- R5: With mask 10'b0000110011 and `cnt_en` high after reset, the output runs 0x000, 0x001, 0x002, 0x003, 0x010, 0x011, 0x012 on successive edges.
- R6: When the output equals the mask (all selected bits set), the next enabled edge returns it to zero. The period is 2^k for k set mask bits.
- R7: A mask change is visible on the output in the same cycle, without a clock edge. The counter's low bits are redistributed under the new mask, and the count itself is unchanged.
- R8: With an all-zero mask, the output stays zero whatever the value of `cnt_en`.
- R9: The width is the parameter `WIDTH`, default 10. The mask and the output both have that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, active high |
| sel_mask | input | WIDTH | Select mask; bit 1 marks a counting position |
| count_out | output | WIDTH | Scattered count value |

## Verification
An enabled step or a reset takes effect at the first rising edge that sees it. The output shows the new value after that edge, so the bench drives inputs on falling edges and compares one quarter period after each rising edge. A mask change has no register in its path. Its check is made two nanoseconds after the falling edge that changed the mask, before any rising edge can move the count. On every clock, a behavioural integer model is compared with the output, and the fixed mask sequence, the wrap points and the zero-mask case are also checked against literal values.

// File: rtl/scnt_pkg.sv
package scnt_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_CLEAR = 2'd1,
        STEP_INC   = 2'd2,
        STEP_WRAP  = 2'd3
    } step_e;
endpackage

// File: rtl/scnt_span.sv
// Counts the selected positions and builds a mask of that many low ones.
module scnt_span #(
    parameter int WIDTH = 10,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] sel_mask,
    output logic [WIDTH-1:0] span,
    output logic [CW-1:0]    sel_count
);
    always_comb begin
        sel_count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            sel_count = sel_count + CW'(sel_mask[i]);
        end
    end

    always_comb begin
        for (int j = 0; j < WIDTH; j++) begin
            span[j] = (CW'(j) < sel_count);
        end
    end
endmodule

// File: rtl/scnt_core.sv
// Binary counter; wraps when the low sel_count bits are all ones.
module scnt_core
    import scnt_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] span,
    output logic [WIDTH-1:0] ctr
);
    step_e            step;
    logic             terminal;
    logic [WIDTH-1:0] ctr_next;

    assign terminal = &(ctr | ~span);

    // Decision stage: one named action per edge.
    always_comb begin
        if (rst)            step = STEP_CLEAR;
        else if (!cnt_en)   step = STEP_HOLD;
        else if (terminal)  step = STEP_WRAP;
        else                step = STEP_INC;
    end

    always_comb begin
        unique case (step)
            STEP_CLEAR: ctr_next = '0;
            STEP_HOLD:  ctr_next = ctr;
            STEP_WRAP:  ctr_next = '0;
            STEP_INC:   ctr_next = ctr + WIDTH'(1);
            default:    ctr_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        ctr <= ctr_next;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> ctr == '0);
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(ctr));
    assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && (&(ctr | ~span))) |=> ctr == '0);
    assert_step_by_one_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !(&(ctr | ~span))) |=> ctr == $past(ctr) + WIDTH'(1));
endmodule

// File: rtl/scnt_deposit.sv
// Places src bit r at the r-th set position of sel_mask.
module scnt_deposit #(
    parameter int WIDTH = 10,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] sel_mask,
    output logic [WIDTH-1:0] dst
);
    logic [IW-1:0] rank [WIDTH];

    always_comb begin
        rank[0] = '0;
        for (int i = 1; i < WIDTH; i++) begin
            rank[i] = rank[i-1] + IW'(sel_mask[i-1]);
        end
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        assign dst[g] = sel_mask[g] & src[rank[g]];
    end
endmodule

// File: rtl/scatter_counter.sv
module scatter_counter #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] sel_mask,
    output logic [WIDTH-1:0] count_out
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] span;
    logic [CW-1:0]    sel_count;
    logic [WIDTH-1:0] ctr;

    scnt_span #(.WIDTH(WIDTH)) u_span (
        .sel_mask  (sel_mask),
        .span      (span),
        .sel_count (sel_count)
    );

    scnt_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .span   (span),
        .ctr    (ctr)
    );

    scnt_deposit #(.WIDTH(WIDTH)) u_dep (
        .src      (ctr),
        .sel_mask (sel_mask),
        .dst      (count_out)
    );

    assert_unselected_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (count_out & ~sel_mask) == '0);
    assert_empty_mask_zero_R8: assert property (@(posedge clk) disable iff (rst)
        sel_mask == '0 |-> count_out == '0);
    assert_popcount_bound_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(count_out) <= int'(sel_count));
    assert_idle_output_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && $stable(sel_mask)) |=> $stable(count_out));
endmodule

// File: tb/scatter_counter_tb.sv
`timescale 1ns/1ps
module scatter_counter_tb;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0;
    logic [W-1:0] sel_mask = 10'h033;
    logic [W-1:0] count_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_tag = "R1";
    int unsigned model_ctr = 0;

    always #10 clk = ~clk;

    scatter_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .sel_mask(sel_mask), .count_out(count_out)
    );

    function automatic logic [W-1:0] place(int unsigned c, logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin
                r[i] = c[k];
                k++;
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Reference model and per-clock comparison.
    always @(posedge clk) begin
        int k;
        int unsigned low;
        k = $countones(sel_mask);
        low = (32'd1 << k) - 1;
        if (rst) model_ctr = 0;
        else if (cnt_en) begin
            if ((model_ctr & low) == low) model_ctr = 0;
            else model_ctr = model_ctr + 1;
        end
        #5;
        check(cur_tag, count_out, place(model_ctr, sel_mask));
        check("R2", count_out & ~sel_mask, '0);
    end

    task automatic edges(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #6;
        end
    endtask

    task automatic drive(logic r, logic e, logic [W-1:0] m);
        @(negedge clk);
        rst = r; cnt_en = e; sel_mask = m;
    endtask

    initial begin
        logic [W-1:0] seq [7];
        seq = '{10'h000, 10'h001, 10'h002, 10'h003, 10'h010, 10'h011, 10'h012};

        cur_tag = "R1";
        drive(1'b1, 1'b1, 10'h033);
        edges(3);
        check("R1 reset", count_out, 10'h000);

        // Example sequence from reset
        cur_tag = "R5";
        drive(1'b0, 1'b1, 10'h033);
        check("R5 seq0", count_out, seq[0]);
        for (int i = 1; i < 7; i++) begin
            edges(1);
            check("R5 seq", count_out, seq[i]);
        end
        // 6 steps taken; 9 more reach the mask, one more wraps
        cur_tag = "R6";
        edges(9);
        check("R6 last equals mask", count_out, 10'h033);
        edges(1);
        check("R6 wrap", count_out, 10'h000);

        // Hold
        edges(3);
        cur_tag = "R4";
        drive(1'b0, 1'b0, 10'h033);
        edges(4);
        check("R4 hold", count_out, place(3, 10'h033));

        // Reset beats enable
        cur_tag = "R1";
        drive(1'b1, 1'b1, 10'h033);
        edges(1);
        check("R1 priority", count_out, 10'h000);

        // Mask change mid-count
        cur_tag = "R3";
        drive(1'b0, 1'b1, 10'h033);
        edges(5);
        check("R3 five", count_out, 10'h011);
        @(negedge clk);
        cnt_en = 1'b0; sel_mask = 10'h3C0;
        #2;
        check("R7 remap", count_out, 10'h140);
        cur_tag = "R7";
        drive(1'b0, 1'b1, 10'h3C0);
        edges(20);

        // Zero mask
        cur_tag = "R8";
        drive(1'b0, 1'b1, 10'h000);
        edges(5);
        check("R8 zero mask en", count_out, 10'h000);
        drive(1'b0, 1'b0, 10'h000);
        edges(2);
        check("R8 zero mask idle", count_out, 10'h000);

        // Single bit: period two
        cur_tag = "R6";
        drive(1'b1, 1'b0, 10'h200);
        edges(1);
        drive(1'b0, 1'b1, 10'h200);
        edges(1);
        check("R6 single set", count_out, 10'h200);
        edges(1);
        check("R6 single wrap", count_out, 10'h000);

        // Full mask: plain binary, full period
        cur_tag = "R3";
        drive(1'b1, 1'b0, 10'h3FF);
        edges(1);
        drive(1'b0, 1'b1, 10'h3FF);
        edges(1023);
        check("R6 full last", count_out, 10'h3FF);
        edges(1);
        check("R6 full wrap", count_out, 10'h000);

        n_cmp++;
        if ($bits(count_out) != 10) begin
            n_bad++;
            $display("FAIL R9: width %0d expected 10", $bits(count_out));
        end

        finish_run();
    end

    initial begin
        #(20 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule